// File: doc/BRIEF.md
# Three-Byte Pressure Sample Reader (I2C Master)

This block is a small I2C bus master that fetches one 24-bit pressure sample from a sensor at a fixed 7-bit slave address. A one-clock request on `start_i` starts a fixed read transaction. The block issues a START condition and sends the address with the read bit set. It then checks the slave's acknowledge, clocks in three data bytes and ends with a STOP condition. Three outputs report the transaction: `busy_o` while it runs, a one-clock `valid_o` with the assembled word on `data_o`, and `err_o` when the slave fails to acknowledge its address.

Both bus lines are open-drain. The block only pulls a line low, through its drive-low enable, and it reads the resolved line level back. The system clock can be as slow as 32.768 kHz, so each bit is cut into four quarter phases. Every quarter lasts `QTR_CLKS` system clocks. There is no clock stretching, no arbitration and no write access.

Top module: `press_rd_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, both drive-low enables are deasserted. After reset `busy_o`, `valid_o` and `err_o` are 0 and `data_o` is 0.
- R2: Each transaction begins with one SDA fall while SCL is high (START) and ends with one SDA rise while SCL is high (STOP). Between them SDA changes only while SCL is low.
- R3: The first byte on the bus is the slave address 0001000 followed by the read bit 1, sent most-significant bit first. This is the byte value 0x11.
- R4: In the acknowledge clock that follows each of the first two data bytes, the master holds SDA low (ACK). After the third data byte it leaves SDA high (NACK).
- R5: Data bits are received most-significant bit first. The first received byte lands in `data_o[7:0]`, the second in `data_o[15:8]` and the third in `data_o[23:16]`. For example, bytes CD, 8B, 01 give 0x018BCD.
- R6: `valid_o` is high for exactly one clock per successful transaction. That clock is the first one with `busy_o` low after STOP. `data_o` changes only in that clock.
- R7: If SDA is high during the address acknowledge clock, the block sets `err_o`, goes straight to STOP and reads no data bytes. `valid_o` stays low and `data_o` keeps its previous value. `err_o` stays set until the next accepted request clears it.
- R8: Each quarter bit phase lasts `QTR_CLKS` clocks. `busy_o` stays high for 152 quarters in a full transaction and 44 quarters in one aborted at the address.
- R9: A `start_i` pulse while `busy_o` is high has no effect. The running transaction keeps its length and produces a single START and a single result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to read a sample |
| busy_o | output | 1 | High while a transaction is in progress |
| valid_o | output | 1 | One-clock strobe: `data_o` holds a new sample |
| err_o | output | 1 | Last transaction was not acknowledged at its address |
| data_o | output | 24 | Assembled sample, first received byte least significant |
| scl_lo_o | output | 1 | Drive-low enable for SCL |
| scl_i | input | 1 | Resolved SCL line level |
| sda_lo_o | output | 1 | Drive-low enable for SDA |
| sda_i | input | 1 | Resolved SDA line level |

## Verification
Assertions watch several rules on every clock. SDA must hold steady while SCL is high within the bit phases. The lines must be released whenever the block is idle. `valid_o` must be a single clock, taken only when idle and never together with `err_o`, and `data_o` may move only with it. The quarter counter must stay in range. Other behaviour needs the bench's modelled slave and its bus decoding. That covers the address byte on the wire, the ACK/NACK pattern, byte ordering in the result, transaction length, recovery from an address NACK, and ignored requests. These are checked over several sensor byte patterns.

// File: rtl/prd_pkg.sv
package prd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_BITS  = 2'd2,
      ST_STOP  = 2'd3
   } prd_state_e;

   localparam int unsigned QUARTERS_PER_BIT = 4;
   localparam int unsigned SLOTS_PER_FRAME  = 9;
endpackage

// File: rtl/prd_qtr_timer.sv
module prd_qtr_timer #(
   parameter int QTR_CLKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(QTR_CLKS - 1);

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   // R8: quarter counter never passes its terminal count
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R8: an idle timer restarts at zero
   a_r8_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
endmodule

// File: rtl/prd_rx_assemble.sv
module prd_rx_assemble #(
   parameter int NBYTES = 3,
   parameter int FW     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shift_en,
   input  logic                  bit_in,
   input  logic                  last_bit,
   input  logic [FW-1:0]         frm,
   output logic [8*NBYTES-1:0]   word
);
   logic [6:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh <= '0;
      else if (shift_en) sh <= {sh[5:0], bit_in};
   end

   // one capture slot per byte; frame k+1 lands in byte lane k
   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      logic [7:0] lane;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane <= '0;
         else if (shift_en && last_bit && (frm == FW'(k + 1)))
            lane <= {sh, bit_in};
      end
      assign word[8*k +: 8] = lane;
   end
endmodule

// File: rtl/press_rd_master.sv
module press_rd_master #(
   parameter logic [6:0] SLV_ADDR = 7'b0001000,
   parameter int         QTR_CLKS = 1,
   parameter int         NBYTES   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic                busy_o,
   output logic                valid_o,
   output logic                err_o,
   output logic [8*NBYTES-1:0] data_o,
   output logic                scl_lo_o,
   input  logic                scl_i,
   output logic                sda_lo_o,
   input  logic                sda_i
);
   import prd_pkg::*;

   localparam int FW = $clog2(NBYTES + 1);
   localparam int DW = 8 * NBYTES;
   localparam logic [7:0] ADDR_RD = {SLV_ADDR, 1'b1};
   localparam logic [3:0] ACK_SLOT = 4'(SLOTS_PER_FRAME - 1);

   if (QTR_CLKS < 1) begin : g_bad_qtr
      $error("QTR_CLKS must be at least 1");
   end
   if (NBYTES < 1) begin : g_bad_nbytes
      $error("NBYTES must be at least 1");
   end

   prd_state_e    st;
   logic [1:0]    q;
   logic [3:0]    bidx;
   logic [FW-1:0] frm;
   logic          sda_lo_q, err_q, valid_q;
   logic [DW-1:0] data_q, acc;
   logic          tick, ack_slot, want_lo, shift_en;

   prd_qtr_timer #(.QTR_CLKS(QTR_CLKS)) i_timer (
      .clk(clk), .rst_n(rst_n), .run(busy_o), .tick(tick));

   assign ack_slot = (bidx == ACK_SLOT);
   assign shift_en = tick && (st == ST_BITS) && (q == 2'd2) &&
                     (frm != '0) && !ack_slot;

   prd_rx_assemble #(.NBYTES(NBYTES), .FW(FW)) i_rx (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sda_i),
      .last_bit(bidx == 4'd7), .frm(frm), .word(acc));

   // SDA pull-down wanted for the current slot
   always_comb begin
      if (frm == '0)
         want_lo = ack_slot ? 1'b0 : ~ADDR_RD[3'd7 - bidx[2:0]];
      else
         want_lo = ack_slot ? (frm != FW'(NBYTES)) : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; q <= '0; bidx <= '0; frm <= '0;
         sda_lo_q <= 1'b0; err_q <= 1'b0; valid_q <= 1'b0; data_q <= '0;
      end else begin
         valid_q <= 1'b0;
         case (st)
            ST_IDLE: if (start_i) begin
               st <= ST_START; q <= '0; bidx <= '0; frm <= '0; err_q <= 1'b0;
            end
            ST_START: if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd0) sda_lo_q <= 1'b1;
               if (q == 2'd3) st <= ST_BITS;
            end
            ST_BITS: if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd0) sda_lo_q <= want_lo;
               if (q == 2'd2 && frm == '0 && ack_slot) err_q <= sda_i;
               if (q == 2'd3) begin
                  if (ack_slot) begin
                     bidx <= '0;
                     if ((frm == '0 && err_q) || frm == FW'(NBYTES)) st <= ST_STOP;
                     else frm <= frm + 1'b1;
                  end else begin
                     bidx <= bidx + 4'd1;
                  end
               end
            end
            ST_STOP: if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd0) sda_lo_q <= 1'b1;
               if (q == 2'd2) sda_lo_q <= 1'b0;
               if (q == 2'd3) begin
                  st <= ST_IDLE;
                  if (!err_q) begin
                     valid_q <= 1'b1;
                     data_q  <= acc;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (st != ST_IDLE);
   assign scl_lo_o = ((st == ST_BITS) || (st == ST_STOP)) && (q < 2'd2);
   assign sda_lo_o = sda_lo_q;
   assign valid_o  = valid_q;
   assign err_o    = err_q;
   assign data_o   = data_q;

   // R1: bus released whenever idle
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_lo_o && !sda_lo_o));
   // R2: inside bit phases SDA holds while SCL stays high
   a_r2_sda_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BITS && !scl_lo_o && $past(!scl_lo_o)) |-> $stable(sda_lo_o));
   // R2: a released SCL reads back high (no stretching expected)
   a_r2_scl_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_lo_o && $past(!scl_lo_o)) |-> scl_i);
   // R6: strobe lasts one clock and comes with busy low
   a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   a_r6_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !busy_o);
   // R6: result word moves only with the strobe
   a_r6_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_o) |-> valid_o);
   // R7: a failed address never produces a result
   a_r7_no_valid_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !err_o);
endmodule

// File: tb/test_press_rd_master.sv
module test_press_rd_master;
   localparam int Q    = 2;
   localparam int NV   = 6;
   localparam int FULL = 152 * Q;
   localparam int ABRT = 44 * Q;

   // {slave acks address, byte1, byte2, byte3, expected err, expected data}
   localparam logic [49:0] VEC [NV] = '{
      {1'b1, 8'hCD, 8'h8B, 8'h01, 1'b0, 24'h018BCD},
      {1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, 24'hFFFFFF},
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 24'h000000},
      {1'b1, 8'h5A, 8'hA5, 8'h3C, 1'b0, 24'h3CA55A},
      {1'b0, 8'h12, 8'h34, 8'h56, 1'b1, 24'h3CA55A},
      {1'b1, 8'h01, 8'h80, 8'h7F, 1'b0, 24'h7F8001}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic busy, valid, err, scl_lo, sda_lo;
   logic [23:0] data;
   logic slv_lo = 1'b0;
   wire  scl = !scl_lo;
   wire  sda = !(sda_lo || slv_lo);

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   press_rd_master #(.QTR_CLKS(Q)) i_press_rd_master (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
      .valid_o(valid), .err_o(err), .data_o(data), .scl_lo_o(scl_lo),
      .scl_i(scl), .sda_lo_o(sda_lo), .sda_i(sda));

   // behavioural slave
   logic       prev_scl = 1'b1, prev_sda = 1'b1, active = 1'b0;
   logic       s_ack = 1'b1, addr_ok = 1'b0;
   logic [7:0] sb [3];
   logic [7:0] addr_rx = '0;
   logic [3:0] mack = '1;
   int bitn = 0, byten = 0, n_start = 0, n_stop = 0;
   int busy_cyc = 0, valid_cyc = 0;

   always @(negedge clk) begin
      if (scl && prev_scl && prev_sda && !sda) begin
         n_start++; active = 1'b1; bitn = 15; byten = 0; slv_lo = 1'b0;
         addr_rx = '0; addr_ok = 1'b0;
      end else if (scl && prev_scl && !prev_sda && sda) begin
         n_stop++; active = 1'b0; slv_lo = 1'b0;
      end else if (active && scl && !prev_scl) begin
         if (byten == 0 && bitn < 8) addr_rx = {addr_rx[6:0], sda};
         if (byten >= 1 && byten <= 3 && bitn == 8) mack[byten] = sda;
      end else if (active && !scl && prev_scl) begin
         if (bitn == 15) bitn = 0;
         else if (bitn == 8) begin bitn = 0; byten++; end
         else bitn++;
         if (byten == 0 && bitn == 8) begin
            addr_ok = s_ack && (addr_rx == 8'h11);
            slv_lo  = addr_ok;
         end else if (byten >= 1 && byten <= 3 && bitn < 8 && addr_ok)
            slv_lo = !sb[byten-1][7-bitn];
         else
            slv_lo = 1'b0;
      end
      prev_scl = scl;
      prev_sda = !(sda_lo || slv_lo);
   end

   always @(negedge clk) begin
      if (busy)  busy_cyc++;
      if (valid) valid_cyc++;
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_txn(logic ack, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                          bit extra_req);
      s_ack = ack; sb[0] = b0; sb[1] = b1; sb[2] = b2;
      n_start = 0; n_stop = 0; busy_cyc = 0; valid_cyc = 0; mack = '1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (extra_req) begin
         repeat (20) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
         repeat (200) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      for (int g = 0; g < 4000 && busy; g++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "valid", 32'(valid), 0);
      chk("R1", "err", 32'(err), 0);
      chk("R1", "data", 32'(data), 0);
      chk("R1", "lines", {30'd0, scl_lo, sda_lo}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run_txn(VEC[v][49], VEC[v][48:41], VEC[v][40:33], VEC[v][32:25], 1'b0);
         chk("R5", "data", 32'(data), 32'(VEC[v][23:0]));
         chk("R7", "err", 32'(err), 32'(VEC[v][24]));
         chk("R6", "valid cycles", valid_cyc, VEC[v][24] ? 0 : 1);
         chk("R8", "busy cycles", busy_cyc, VEC[v][24] ? ABRT : FULL);
         chk("R2", "start count", n_start, 1);
         chk("R2", "stop count", n_stop, 1);
         chk("R3", "address byte", 32'(addr_rx), 32'h11);
         if (!VEC[v][24]) chk("R4", "master ack bits", 32'(mack[3:1]), 32'b100);
         else             chk("R7", "no data acks", 32'(mack[3:1]), 32'b111);
         chk("R1", "lines idle", {30'd0, scl_lo, sda_lo}, 0);
      end

      // R9: requests while busy are ignored
      run_txn(1'b1, 8'h34, 8'h12, 8'h00, 1'b1);
      chk("R9", "start count", n_start, 1);
      chk("R9", "valid cycles", valid_cyc, 1);
      chk("R9", "busy cycles", busy_cyc, FULL);
      chk("R9", "data", 32'(data), 32'h001234);

      // R7: error clears on next accepted request, then reappears on NACK
      run_txn(1'b0, 8'hAA, 8'hBB, 8'hCC, 1'b0);
      chk("R7", "err set", 32'(err), 1);
      chk("R7", "data kept", 32'(data), 32'h001234);
      run_txn(1'b1, 8'hEF, 8'hBE, 8'hAD, 1'b0);
      chk("R7", "err cleared", 32'(err), 0);
      chk("R5", "data", 32'(data), 32'hADBEEF);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule